// File: doc/BRIEF.md
# Coprocessor Exception Decision Sequencer

This block sits beside the instruction sequencer of a main processor and decides which exceptions are taken while coprocessor-interface instructions execute. For each decided exception it presents a vector number, a stack frame format code and the program counter value to be saved. The surrounding core then builds the frame and fetches the handler. The block also gates the communication request for each coprocessor instruction. When required, it aborts the coprocessor through a one-cycle write of a fixed mask to the coprocessor control register.

Three kinds of input drive it:
- an instruction strobe with the decoded class and the instruction address;
- the primitive responses returned by the coprocessor;
- a completion strobe with the PC after the instruction, the next sequential PC and a flag that the status register was written.

Privilege faults restart the faulting instruction, so they use the short pre-instruction frame. Conditional traps and traces resume after the instruction, so they use the longer post-instruction frame. Each exception is a one-cycle valid pulse. The fields stay stable until the next exception. The core acknowledges each exception before the block accepts new work.

Top module: `cpx_exc_seq`

## Requirements
- R1: An instruction of class save (01) or restore (10) strobed while `sup_bit` is 0 gives, one cycle later, a privilege exception: vector 8, frame code 0, saved PC equal to `ins_pc`. It raises no `cp_req` for that instruction. Any other accepted instruction gives a one-cycle `cp_req` one cycle after the strobe.
- R2: A supervisor-check primitive (code 4) received in user state for a live instruction gives, one cycle later, a one-cycle `abort_req` with the fixed abort mask on `abort_mask` (zero at all other times). No exception is raised until `abort_done` is sampled. One cycle after that, a privilege exception appears with vector 8, frame code 0 and the instruction's own address. No trace follows it.
- R3: A supervisor-check primitive in supervisor state has no effect. So does any primitive code other than 0 and 4, and any primitive arriving when no instruction is live.
- R4: A null primitive (code 0) with `prim_cond` 1 during a conditional-trap instruction (class 11) raises a trap one cycle after that instruction's completion strobe. The trap has vector 7, frame code 2 and a saved PC equal to `done_seq_pc`. A null primitive with `prim_cond` 0, or one received in any other class, raises no trap.
- R5: With trace mode 10, each completion strobe raises a trace one cycle later. The trace has vector 9, frame code 2 and a saved PC equal to `done_new_pc`.
- R6: With trace mode 01, a completion raises a trace only when `done_sr_wr` is 1 or `done_new_pc` differs from `done_seq_pc`.
- R7: Trace modes 00 and 11 raise no trace.
- R8: When one completion qualifies for both a trap and a trace, the trap is presented first. The trace is presented one cycle after the trap is acknowledged.
- R9: `exc_valid` is high for exactly one cycle per exception, unless `exc_ack` in that same cycle releases a held trace. The vector, frame and PC outputs keep their values until the next exception.
- R10: After an exception is raised and until it is acknowledged, and while an abort waits for `abort_done`, all instruction, primitive and completion strobes are ignored. In one idle cycle, an instruction strobe takes precedence over a primitive, and a primitive takes precedence over a completion.
- R11: During and right after reset, all outputs are 0 and no instruction is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_bit | input | 1 | Current supervisor state bit |
| trace_mode | input | 2 | 00 off, 10 every instruction, 01 change of flow, 11 off |
| ins_valid | input | 1 | Coprocessor instruction decoded strobe |
| ins_class | input | 2 | 00 general, 01 save, 10 restore, 11 conditional trap |
| ins_pc | input | PC_W | Address of the strobed instruction |
| cp_req | output | 1 | One-cycle request to start coprocessor communication |
| prim_valid | input | 1 | Primitive response strobe |
| prim_code | input | PRIM_W | Primitive code, 0 null, 4 supervisor check |
| prim_cond | input | 1 | Condition indicator carried by a null primitive |
| done_valid | input | 1 | Instruction completion strobe |
| done_new_pc | input | PC_W | PC after the completed instruction |
| done_seq_pc | input | PC_W | Next sequential instruction address |
| done_sr_wr | input | 1 | Completed instruction wrote the status register |
| abort_req | output | 1 | One-cycle write request to the coprocessor control register |
| abort_mask | output | MASK_W | Abort mask value, valid with `abort_req` |
| abort_done | input | 1 | Control register write finished |
| exc_valid | output | 1 | Exception decided this cycle |
| exc_vector | output | 8 | Exception vector number |
| exc_frame | output | 4 | Stack frame format code |
| exc_pc | output | PC_W | PC value to save in the frame |
| exc_ack | input | 1 | Core has taken the presented exception |

## Verification
The bench aims at the user-state supervisor-check path with a slow `abort_done`. A design that raised the fault early, or saved the wrong PC, would raise the exception before the abort write completed or restart the wrong instruction. It drives a trapping conditional-trap instruction under every-instruction tracing. A wrong ordering would show the trace first, lose it, or show it before the acknowledge. It fires primitives, new instructions and completions while an exception is still unacknowledged. A design that failed to ignore them would produce an extra abort, a stray `cp_req` or a second exception. Trace modes are swept over sequential completions, branching completions and completions that write the status register, including the reserved code.

// File: rtl/cpx_exc_pkg.sv
// Package: shared encodings for the coprocessor exception sequencer.
// Assumes an 8-bit vector number and a 4-bit frame format code.
package cpx_exc_pkg;

    localparam int VEC_W = 8;
    localparam int FRM_W = 4;

    // Decoded coprocessor instruction class
    typedef enum logic [1:0] {
        CLS_GEN   = 2'b00,
        CLS_SAVE  = 2'b01,
        CLS_REST  = 2'b10,
        CLS_CTRAP = 2'b11
    } cls_t;

    // Sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ABORT = 2'b01,
        ST_HOLD  = 2'b10
    } seq_st_t;

    localparam logic [VEC_W-1:0] VEC_TRAP  = 8'd7;
    localparam logic [VEC_W-1:0] VEC_PRIV  = 8'd8;
    localparam logic [VEC_W-1:0] VEC_TRACE = 8'd9;

    localparam logic [FRM_W-1:0] FRM_PRE  = 4'd0;
    localparam logic [FRM_W-1:0] FRM_POST = 4'd2;

endpackage

// File: rtl/cpx_prim_decode.sv
// Module: classifies a coprocessor primitive response.
// Asserts want_abort for a supervisor check seen in user state, and
// want_trap for a null primitive with TRUE condition in a trap-class
// instruction. Assumes the caller only acts when an instruction is live.
module cpx_prim_decode #(
    parameter int PRIM_W      = 5,
    parameter int CODE_NULL   = 0,
    parameter int CODE_SUPCHK = 4
) (
    input  logic              prim_valid,
    input  logic [PRIM_W-1:0] prim_code,
    input  logic              prim_cond,
    input  logic              sup_bit,
    input  logic              instr_live,
    input  logic              is_ctrap,
    output logic              want_abort,
    output logic              want_trap
);
    localparam logic [PRIM_W-1:0] NULL_C   = PRIM_W'(CODE_NULL);
    localparam logic [PRIM_W-1:0] SUPCHK_C = PRIM_W'(CODE_SUPCHK);

    logic live_prim;

    // Qualify the strobe with a live instruction
    always_comb begin
        live_prim  = prim_valid && instr_live;
        want_abort = live_prim && (prim_code == SUPCHK_C) && !sup_bit;
        want_trap  = live_prim && (prim_code == NULL_C) && prim_cond && is_ctrap;
    end
endmodule

// File: rtl/cpx_trace_qual.sv
// Module: decides whether a completed instruction earns a trace.
// Mode 10 traces every instruction, 01 traces flow changes and
// status-register writes, 00 and 11 never trace.
module cpx_trace_qual #(
    parameter int PC_W = 32
) (
    input  logic [1:0]      trace_mode,
    input  logic            sr_wr,
    input  logic [PC_W-1:0] new_pc,
    input  logic [PC_W-1:0] seq_pc,
    output logic            take_trace
);
    // Select the trace rule by mode
    always_comb begin
        unique case (trace_mode)
            2'b10:   take_trace = 1'b1;
            2'b01:   take_trace = sr_wr || (new_pc != seq_pc);
            default: take_trace = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpx_exc_out.sv
// Module: output register for one decided exception.
// A load raises a one-cycle valid pulse and latches vector, frame and
// PC; the fields hold until the next load.
module cpx_exc_out
    import cpx_exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] ld_vec,
    input  logic [FRM_W-1:0] ld_frm,
    input  logic [PC_W-1:0]  ld_pc,
    output logic             exc_valid,
    output logic [VEC_W-1:0] exc_vector,
    output logic [FRM_W-1:0] exc_frame,
    output logic [PC_W-1:0]  exc_pc
);
    // Pulse valid and capture fields on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid  <= 1'b0;
            exc_vector <= '0;
            exc_frame  <= '0;
            exc_pc     <= '0;
        end else begin
            exc_valid <= load;
            if (load) begin
                exc_vector <= ld_vec;
                exc_frame  <= ld_frm;
                exc_pc     <= ld_pc;
            end
        end
    end
endmodule

// File: rtl/cpx_exc_seq.sv
// Module: coprocessor exception decision sequencer (top).
// Tracks one live coprocessor instruction. Raises privilege faults
// for user-mode save/restore and user-mode supervisor checks (the
// latter after an abort write). Raises conditional traps and traces
// at completion, trap first. Holds each exception until acknowledged.
// Assumes the core strobes at most one instruction at a time.
module cpx_exc_seq
    import cpx_exc_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              PRIM_W      = 5,
    parameter int              MASK_W      = 16,
    parameter logic [MASK_W-1:0] ABORT_MASK = 16'h0001,
    parameter int              CODE_NULL   = 0,
    parameter int              CODE_SUPCHK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_bit,
    input  logic [1:0]        trace_mode,
    input  logic              ins_valid,
    input  logic [1:0]        ins_class,
    input  logic [PC_W-1:0]   ins_pc,
    output logic              cp_req,
    input  logic              prim_valid,
    input  logic [PRIM_W-1:0] prim_code,
    input  logic              prim_cond,
    input  logic              done_valid,
    input  logic [PC_W-1:0]   done_new_pc,
    input  logic [PC_W-1:0]   done_seq_pc,
    input  logic              done_sr_wr,
    output logic              abort_req,
    output logic [MASK_W-1:0] abort_mask,
    input  logic              abort_done,
    output logic              exc_valid,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [FRM_W-1:0]  exc_frame,
    output logic [PC_W-1:0]   exc_pc,
    input  logic              exc_ack
);
    seq_st_t        st_q, st_d;
    logic           live_q, live_d;
    cls_t           cls_q, cls_d;
    logic [PC_W-1:0] ipc_q, ipc_d;
    logic           trap_q, trap_d;
    logic           thold_q, thold_d;
    logic [PC_W-1:0] tpc_q, tpc_d;
    logic           cp_d, abort_d;

    logic             load;
    logic [VEC_W-1:0] ld_vec;
    logic [FRM_W-1:0] ld_frm;
    logic [PC_W-1:0]  ld_pc;

    logic want_abort, want_trap, take_trace, priv_ins;
    cls_t ins_cls;

    assign ins_cls  = cls_t'(ins_class);
    assign priv_ins = ((ins_cls == CLS_SAVE) || (ins_cls == CLS_REST)) && !sup_bit;

    cpx_prim_decode #(
        .PRIM_W      (PRIM_W),
        .CODE_NULL   (CODE_NULL),
        .CODE_SUPCHK (CODE_SUPCHK)
    ) u_prim (
        .prim_valid (prim_valid),
        .prim_code  (prim_code),
        .prim_cond  (prim_cond),
        .sup_bit    (sup_bit),
        .instr_live (live_q),
        .is_ctrap   (cls_q == CLS_CTRAP),
        .want_abort (want_abort),
        .want_trap  (want_trap)
    );

    cpx_trace_qual #(.PC_W(PC_W)) u_trace (
        .trace_mode (trace_mode),
        .sr_wr      (done_sr_wr),
        .new_pc     (done_new_pc),
        .seq_pc     (done_seq_pc),
        .take_trace (take_trace)
    );

    cpx_exc_out #(.PC_W(PC_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_vec     (ld_vec),
        .ld_frm     (ld_frm),
        .ld_pc      (ld_pc),
        .exc_valid  (exc_valid),
        .exc_vector (exc_vector),
        .exc_frame  (exc_frame),
        .exc_pc     (exc_pc)
    );

    // Next-state and exception-load decision
    always_comb begin
        st_d    = st_q;
        live_d  = live_q;
        cls_d   = cls_q;
        ipc_d   = ipc_q;
        trap_d  = trap_q;
        thold_d = thold_q;
        tpc_d   = tpc_q;
        cp_d    = 1'b0;
        abort_d = 1'b0;
        load    = 1'b0;
        ld_vec  = VEC_PRIV;
        ld_frm  = FRM_PRE;
        ld_pc   = ipc_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ins_valid) begin
                    trap_d = 1'b0;
                    if (priv_ins) begin
                        load   = 1'b1;
                        ld_pc  = ins_pc;
                        live_d = 1'b0;
                        st_d   = ST_HOLD;
                    end else begin
                        cp_d   = 1'b1;
                        live_d = 1'b1;
                        cls_d  = ins_cls;
                        ipc_d  = ins_pc;
                    end
                end else if (prim_valid) begin
                    if (want_abort) begin
                        abort_d = 1'b1;
                        st_d    = ST_ABORT;
                    end else if (want_trap) begin
                        trap_d = 1'b1;
                    end
                end else if (done_valid) begin
                    live_d = 1'b0;
                    trap_d = 1'b0;
                    if (trap_q) begin
                        load    = 1'b1;
                        ld_vec  = VEC_TRAP;
                        ld_frm  = FRM_POST;
                        ld_pc   = done_seq_pc;
                        thold_d = take_trace;
                        tpc_d   = done_new_pc;
                        st_d    = ST_HOLD;
                    end else if (take_trace) begin
                        load   = 1'b1;
                        ld_vec = VEC_TRACE;
                        ld_frm = FRM_POST;
                        ld_pc  = done_new_pc;
                        st_d   = ST_HOLD;
                    end
                end
            end
            ST_ABORT: begin
                if (abort_done) begin
                    load   = 1'b1;
                    ld_pc  = ipc_q;
                    live_d = 1'b0;
                    trap_d = 1'b0;
                    st_d   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (exc_ack) begin
                    if (thold_q) begin
                        load    = 1'b1;
                        ld_vec  = VEC_TRACE;
                        ld_frm  = FRM_POST;
                        ld_pc   = tpc_q;
                        thold_d = 1'b0;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            live_q    <= 1'b0;
            cls_q     <= CLS_GEN;
            ipc_q     <= '0;
            trap_q    <= 1'b0;
            thold_q   <= 1'b0;
            tpc_q     <= '0;
            cp_req    <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            st_q      <= st_d;
            live_q    <= live_d;
            cls_q     <= cls_d;
            ipc_q     <= ipc_d;
            trap_q    <= trap_d;
            thold_q   <= thold_d;
            tpc_q     <= tpc_d;
            cp_req    <= cp_d;
            abort_req <= abort_d;
        end
    end

    // Mask is driven only alongside the write request
    assign abort_mask = abort_req ? ABORT_MASK : '0;

endmodule

// File: rtl/cpx_exc_seq_chk.sv
// Module: protocol checker bound to cpx_exc_seq.
// Watches pulses, frame pairing and output stability at the ports.
module cpx_exc_seq_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cp_req,
    input logic            abort_req,
    input logic            exc_valid,
    input logic [7:0]      exc_vector,
    input logic [3:0]      exc_frame,
    input logic [PC_W-1:0] exc_pc,
    input logic            exc_ack
);
    // R9
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !exc_ack |=> !exc_valid);

    // R2
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    // R2
    abort_noexc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !exc_valid);

    // R1
    priv_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_vector == 8'd8 |-> exc_frame == 4'd0 && !cp_req);

    // R4
    post_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_vector != 8'd8 |->
            exc_frame == 4'd2 && (exc_vector == 8'd7 || exc_vector == 8'd9));

    // R9
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !exc_valid |->
            $stable(exc_vector) && $stable(exc_frame) && $stable(exc_pc));

endmodule

bind cpx_exc_seq cpx_exc_seq_chk #(.PC_W(PC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cp_req     (cp_req),
    .abort_req  (abort_req),
    .exc_valid  (exc_valid),
    .exc_vector (exc_vector),
    .exc_frame  (exc_frame),
    .exc_pc     (exc_pc),
    .exc_ack    (exc_ack)
);

// File: tb/cpx_exc_seq_tb_top.sv
// Bench: queue-based reference model compared with the design every cycle.
module cpx_exc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_bit = 1'b0;
    logic [1:0]  trace_mode = 2'b00;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_class = 2'b00;
    logic [31:0] ins_pc = '0;
    logic        cp_req;
    logic        prim_valid = 1'b0;
    logic [4:0]  prim_code = '0;
    logic        prim_cond = 1'b0;
    logic        done_valid = 1'b0;
    logic [31:0] done_new_pc = '0;
    logic [31:0] done_seq_pc = '0;
    logic        done_sr_wr = 1'b0;
    logic        abort_req;
    logic [15:0] abort_mask;
    logic        abort_done = 1'b0;
    logic        exc_valid;
    logic [7:0]  exc_vector;
    logic [3:0]  exc_frame;
    logic [31:0] exc_pc;
    logic        exc_ack = 1'b0;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    cpx_exc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sup_bit(sup_bit), .trace_mode(trace_mode),
        .ins_valid(ins_valid), .ins_class(ins_class), .ins_pc(ins_pc),
        .cp_req(cp_req), .prim_valid(prim_valid), .prim_code(prim_code),
        .prim_cond(prim_cond), .done_valid(done_valid), .done_new_pc(done_new_pc),
        .done_seq_pc(done_seq_pc), .done_sr_wr(done_sr_wr), .abort_req(abort_req),
        .abort_mask(abort_mask), .abort_done(abort_done), .exc_valid(exc_valid),
        .exc_vector(exc_vector), .exc_frame(exc_frame), .exc_pc(exc_pc),
        .exc_ack(exc_ack)
    );

    // Reference model
    typedef struct packed {logic [7:0] v; logic [3:0] f; logic [31:0] p;} ent_t;
    ent_t q[$];
    int   m_st = 0;
    bit   m_live = 0, m_trap = 0;
    int   m_cls = 0;
    logic [31:0] m_ipc = 0;
    logic m_valid = 0, m_cp = 0, m_abort = 0;
    logic [7:0]  m_vec = 0;
    logic [3:0]  m_frm = 0;
    logic [31:0] m_pc = 0;

    function automatic void m_present();
        ent_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            m_vec = e.v; m_frm = e.f; m_pc = e.p; m_valid = 1; m_st = 2;
        end else begin
            m_st = 0;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_st = 0; m_live = 0; m_trap = 0; m_cls = 0; m_ipc = 0;
            m_valid = 0; m_cp = 0; m_abort = 0; m_vec = 0; m_frm = 0; m_pc = 0;
        end else begin
            m_valid = 0; m_cp = 0; m_abort = 0;
            if (m_st == 0) begin
                if (ins_valid) begin
                    m_trap = 0;
                    if ((ins_class == 1 || ins_class == 2) && !sup_bit) begin
                        q.push_back({8'd8, 4'd0, ins_pc});
                        m_live = 0;
                        m_present();
                    end else begin
                        m_cp = 1; m_live = 1; m_cls = ins_class; m_ipc = ins_pc;
                    end
                end else if (prim_valid) begin
                    if (m_live && prim_code == 4 && !sup_bit) begin
                        m_abort = 1; m_st = 1;
                    end else if (m_live && prim_code == 0 && prim_cond && m_cls == 3) begin
                        m_trap = 1;
                    end
                end else if (done_valid) begin
                    m_live = 0;
                    if (m_trap) q.push_back({8'd7, 4'd2, done_seq_pc});
                    if (trace_mode == 2'b10 ||
                        (trace_mode == 2'b01 && (done_sr_wr || done_new_pc != done_seq_pc)))
                        q.push_back({8'd9, 4'd2, done_new_pc});
                    m_trap = 0;
                    m_present();
                end
            end else if (m_st == 1) begin
                if (abort_done) begin
                    q.push_back({8'd8, 4'd0, m_ipc});
                    m_live = 0; m_trap = 0;
                    m_present();
                end
            end else begin
                if (exc_ack) m_present();
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the edge
    initial forever begin
        @(posedge clk);
        #2;
        if (!finished) begin
            chk("exc_valid", 32'(exc_valid), 32'(m_valid));
            chk("exc_vector", 32'(exc_vector), 32'(m_vec));
            chk("exc_frame", 32'(exc_frame), 32'(m_frm));
            chk("exc_pc", exc_pc, m_pc);
            chk("cp_req", 32'(cp_req), 32'(m_cp));
            chk("abort_req", 32'(abort_req), 32'(m_abort));
            chk("abort_mask", 32'(abort_mask), m_abort ? 32'h1 : 32'h0);
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ins(logic [1:0] c, logic s, logic [31:0] pc);
        @(negedge clk);
        ins_valid = 1; ins_class = c; sup_bit = s; ins_pc = pc;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic do_prim(logic [4:0] code, logic cond, logic s);
        @(negedge clk);
        prim_valid = 1; prim_code = code; prim_cond = cond; sup_bit = s;
        @(negedge clk);
        prim_valid = 0;
    endtask

    task automatic do_done(logic [31:0] npc, logic [31:0] spc, logic sr);
        @(negedge clk);
        done_valid = 1; done_new_pc = npc; done_seq_pc = spc; done_sr_wr = sr;
        @(negedge clk);
        done_valid = 0; done_sr_wr = 0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        exc_ack = 1;
        @(negedge clk);
        exc_ack = 0;
    endtask

    task automatic do_abort_done();
        @(negedge clk);
        abort_done = 1;
        @(negedge clk);
        abort_done = 0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R11";
        wait_n(3);
        rst_n = 1;
        wait_n(2);

        cur_req = "R1";
        do_ins(2'b01, 0, 32'h100); wait_n(1); do_ack();
        do_ins(2'b10, 0, 32'h104); do_ack();
        do_ins(2'b10, 1, 32'h108); wait_n(1); do_done(32'h10c, 32'h10c, 0);
        do_ins(2'b00, 0, 32'h110); do_done(32'h114, 32'h114, 0);

        cur_req = "R2";
        do_ins(2'b11, 0, 32'h200); do_prim(5'd4, 0, 0);
        wait_n(4); do_abort_done(); wait_n(1); do_ack();
        trace_mode = 2'b10;
        do_prim(5'd4, 0, 0); wait_n(2);
        trace_mode = 2'b00;

        cur_req = "R3";
        do_ins(2'b00, 1, 32'h300); do_prim(5'd4, 0, 1); do_prim(5'd3, 1, 0);
        do_prim(5'd1, 1, 0); do_done(32'h304, 32'h304, 0); wait_n(2);

        cur_req = "R4";
        do_ins(2'b11, 0, 32'h400); do_prim(5'd0, 1, 0);
        do_done(32'h404, 32'h406, 0); do_ack();
        do_ins(2'b11, 0, 32'h410); do_prim(5'd0, 0, 0); do_done(32'h414, 32'h414, 0);
        do_ins(2'b00, 0, 32'h420); do_prim(5'd0, 1, 0); do_done(32'h424, 32'h424, 0);

        cur_req = "R5";
        trace_mode = 2'b10;
        do_ins(2'b00, 1, 32'h500); do_done(32'h504, 32'h504, 0); do_ack();
        do_done(32'h600, 32'h508, 0); wait_n(2); do_ack();

        cur_req = "R6";
        trace_mode = 2'b01;
        do_done(32'h704, 32'h704, 0); wait_n(1);
        do_done(32'h708, 32'h708, 1); do_ack();
        do_done(32'h800, 32'h70c, 0); do_ack();

        cur_req = "R7";
        trace_mode = 2'b00;
        do_done(32'h900, 32'h804, 1); wait_n(1);
        trace_mode = 2'b11;
        do_done(32'ha00, 32'h904, 1); wait_n(1);

        cur_req = "R8";
        trace_mode = 2'b10;
        do_ins(2'b11, 1, 32'hb00); do_prim(5'd0, 1, 1);
        do_done(32'hb04, 32'hb06, 0); wait_n(2); do_ack(); wait_n(1); do_ack();

        cur_req = "R10";
        trace_mode = 2'b00;
        do_ins(2'b11, 0, 32'hc00); do_prim(5'd0, 1, 0); do_done(32'hc04, 32'hc08, 0);
        do_prim(5'd4, 0, 0); do_ins(2'b01, 0, 32'hc10); do_done(32'hd00, 32'hc14, 1);
        do_ack(); wait_n(2);
        do_ins(2'b00, 0, 32'hc20); do_prim(5'd4, 0, 0);
        do_ins(2'b01, 0, 32'hc30); do_done(32'hd00, 32'hc34, 1);
        do_prim(5'd0, 0, 0); do_abort_done(); wait_n(3); do_ack();

        cur_req = "R9";
        trace_mode = 2'b10;
        do_done(32'he00, 32'he00, 0); wait_n(6); do_ack(); wait_n(3);

        finish_run();
    end
endmodule